// File: doc/BRIEF.md
# Flash Channel Error Capture Unit

This block records and reports error conditions seen on the flash access channel of a serial peripheral controller. The channel's transaction logic presents one completion event per cycle. Each event carries a non-fatal cause code and a fatal cause code, and a code of zero means that class saw no error. For each class the block keeps a sticky status bit and the cause code of the first error. That cause stays frozen until software clears the status bit with a write-1-to-clear.

Each class has its own reporting mode. The mode either silences the class or turns its first error into a system-error request or a system-management interrupt. Clearing an interrupt-routed status sends the matching interrupt release. No report is sent while the host platform is held in reset.

In slave-attached mode the block can also stall the channel. This happens when a non-fatal response arrives to a completion fetch while blocking is enabled. The stall lasts until software clears the blocked bit. The same register also shows whether the table of outstanding non-posted requests is empty, and holds the bit that sets request priority.

Top module: `flash_err_capture`

## Requirements
- R1: After reset the register reads 0x000C0000. This means priority bit [19] = 1 and pending-empty bit [18] = 1, with every other bit 0. All pulse outputs and `chan_block` are low.
- R2: The writable fields read back what was written. They are: non-fatal mode [1:0], fatal mode [3:2], blocking enable [16] and priority [19] (1 = non-posted requests first, 0 = completions first). Bits [31:20] and [7:6] always read 0. Writes to the cause fields [11:8] and [15:12] have no effect.
- R3: An event with a non-zero cause code sets that class's status bit at the next clock edge, whatever its mode. The non-fatal status is bit [4] with its cause in [11:8]. The fatal status is bit [5] with its cause in [15:12].
- R4: While a status bit is set, later errors of that class do not change its cause. Suppose a write of 1 to the status bit lands in the same cycle as a new error of that class. Then the status stays set and the new cause is loaded.
- R5: Writing 1 to bit [4] or bit [5] clears that status bit, unless a new error of the class arrives in the same cycle. Writing 0 leaves it unchanged.
- R6: Mode code 11 routes a class to the interrupt. `smi_assert` pulses for one cycle, at the same edge where a status bit goes from 0 to 1. Mode codes 00 and 01 produce no pulse of any kind.
- R7: Suppose a status bit is cleared by software while its mode is 11. Then `smi_deassert` pulses for one cycle at the clearing edge.
- R8: Mode code 10 routes a class to the system-error request. `serr_req` and `sse_set` pulse together on the 0-to-1 status transition, but only while `serr_cmd_en` is high.
- R9: While `host_in_reset` is high, no `smi_assert`, `smi_deassert`, `serr_req` or `sse_set` pulse is produced. Status and cause capture still take place.
- R10: Non-fatal and fatal errors that arrive in the same cycle are both captured, each in its own fields. Their pulses are merged on the shared outputs.
- R11: The blocked bit [17] and `chan_block` rise when all of the following hold: `slave_mode` is high, blocking enable is 1, the non-fatal code is 1, and `evt_cpl_fetch` is high. Writing 1 to bit [17] clears them. In master mode they never rise.
- R12: Bit [18] follows `np_table_empty` one cycle later while `slave_mode` is high. It reads 1 one cycle after `slave_mode` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_data | output | 32 | Register read value |
| evt_valid | input | 1 | A completion event is present |
| evt_nf_cause | input | 4 | Non-fatal cause code (0 = none) |
| evt_fat_cause | input | 4 | Fatal cause code (0 = none) |
| evt_cpl_fetch | input | 1 | The event is the response to a completion fetch |
| slave_mode | input | 1 | Slave-attached flash mode |
| np_table_empty | input | 1 | No non-posted requests outstanding |
| host_in_reset | input | 1 | Host platform reset is asserted |
| serr_cmd_en | input | 1 | System-error enable from the command register |
| smi_assert | output | 1 | Interrupt assert pulse |
| smi_deassert | output | 1 | Interrupt release pulse |
| serr_req | output | 1 | System-error request pulse |
| sse_set | output | 1 | Pulse that sets the signalled-system-error flag |
| chan_block | output | 1 | Stop issuing flash channel transactions |

## Verification
Every result of this block is due at the first rising edge after the event or write that causes it. This covers status, cause, blocked, pending-empty and every pulse. No result takes two edges. The bench drives stimulus just after a falling edge and holds it for exactly one cycle. It compares the register value and all five outputs against its behavioural model at each following falling edge. A pulse is therefore seen in its single high cycle, and its absence is confirmed in the cycle after. The directed checks read the fields from that same sample point.

// File: rtl/flash_err_pkg.sv
package flash_err_pkg;
  typedef enum logic [1:0] {
    RPT_OFF  = 2'b00,
    RPT_RSVD = 2'b01,
    RPT_SERR = 2'b10,
    RPT_SMI  = 2'b11
  } rpt_mode_e;

  localparam int NUM_CLS    = 2;   // class 0 non-fatal, class 1 fatal
  localparam int MODE_W     = 2;
  localparam int MODE_LSB   = 0;
  localparam int STAT_LSB   = 4;
  localparam int CAUSE_LSB  = 8;
  localparam int BLKEN_BIT  = 16;
  localparam int BLKD_BIT   = 17;
  localparam int EMPTY_BIT  = 18;
  localparam int PRIO_BIT   = 19;
  localparam logic [3:0] NF_FETCH_CODE = 4'd1;
endpackage

// File: rtl/flash_err_class.sv
module flash_err_class
  import flash_err_pkg::*;
#(
  parameter int CAUSE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               evt_valid,
  input  logic [CAUSE_W-1:0] evt_code,
  input  logic               clr_req,
  input  rpt_mode_e          rpt_mode,
  input  logic               host_rst,
  input  logic               serr_cmd_en,
  output logic               status_q,
  output logic [CAUSE_W-1:0] cause_q,
  output logic               smi_on_q,
  output logic               smi_off_q,
  output logic               serr_q
);
  logic hit, rise, fall, may_report;

  assign hit        = evt_valid && (evt_code != '0);
  assign rise       = hit && !status_q;
  assign fall       = clr_req && status_q && !hit;
  assign may_report = !host_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= 1'b0;
      cause_q   <= '0;
      smi_on_q  <= 1'b0;
      smi_off_q <= 1'b0;
      serr_q    <= 1'b0;
    end else begin
      status_q <= hit | (status_q & ~clr_req);
      if (hit && (!status_q || clr_req))
        cause_q <= evt_code;
      smi_on_q  <= rise && may_report && (rpt_mode == RPT_SMI);
      smi_off_q <= fall && may_report && (rpt_mode == RPT_SMI);
      serr_q    <= rise && may_report && serr_cmd_en && (rpt_mode == RPT_SERR);
    end
  end

  // R3
  status_set_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> status_q);
  // R4
  cause_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (status_q && !clr_req) |=> $stable(cause_q));
  // R9
  quiet_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    host_rst |=> !(smi_on_q || smi_off_q || serr_q));
  // R8
  serr_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !serr_cmd_en |=> !serr_q);
  // R6
  smi_pair_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({smi_on_q, smi_off_q}));
endmodule

// File: rtl/flash_err_block.sv
module flash_err_block (
  input  logic clk,
  input  logic rst,
  input  logic slave_mode,
  input  logic blk_en,
  input  logic nf_fetch_err,
  input  logic clr_req,
  output logic blocked_q
);
  logic set_blk;
  assign set_blk = slave_mode && blk_en && nf_fetch_err;

  always_ff @(posedge clk) begin
    if (rst)          blocked_q <= 1'b0;
    else if (set_blk) blocked_q <= 1'b1;
    else if (clr_req) blocked_q <= 1'b0;
  end

  // R11
  master_never_chk: assert property (@(posedge clk) disable iff (rst)
    (!slave_mode && !blocked_q) |=> !blocked_q);
  // R11
  block_set_chk: assert property (@(posedge clk) disable iff (rst)
    set_blk |=> blocked_q);
endmodule

// File: rtl/flash_err_capture.sv
module flash_err_capture
  import flash_err_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [DATA_W-1:0] reg_wr_data,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic              evt_valid,
  input  logic [CAUSE_W-1:0] evt_nf_cause,
  input  logic [CAUSE_W-1:0] evt_fat_cause,
  input  logic              evt_cpl_fetch,
  input  logic              slave_mode,
  input  logic              np_table_empty,
  input  logic              host_in_reset,
  input  logic              serr_cmd_en,
  output logic              smi_assert,
  output logic              smi_deassert,
  output logic              serr_req,
  output logic              sse_set,
  output logic              chan_block
);
  rpt_mode_e                        mode_q [NUM_CLS];
  logic [NUM_CLS-1:0][CAUSE_W-1:0]  codes, causes;
  logic [NUM_CLS-1:0]               stat, smi_on, smi_off, serr_v;
  logic blk_en_q, prio_q, empty_q, blocked;
  logic unused_wr;

  assign codes[0] = evt_nf_cause;
  assign codes[1] = evt_fat_cause;
  assign unused_wr = ^{reg_wr_data[DATA_W-1:PRIO_BIT+1], reg_wr_data[EMPTY_BIT],
                       reg_wr_data[CAUSE_LSB+NUM_CLS*CAUSE_W-1:STAT_LSB+NUM_CLS]};

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_en_q <= 1'b0;
      prio_q   <= 1'b1;
      empty_q  <= 1'b1;
    end else begin
      empty_q <= slave_mode ? np_table_empty : 1'b1;
      if (reg_wr_en) begin
        blk_en_q <= reg_wr_data[BLKEN_BIT];
        prio_q   <= reg_wr_data[PRIO_BIT];
      end
    end
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    always_ff @(posedge clk) begin
      if (rst) mode_q[c] <= RPT_OFF;
      else if (reg_wr_en)
        mode_q[c] <= rpt_mode_e'(reg_wr_data[MODE_LSB+MODE_W*c +: MODE_W]);
    end

    flash_err_class #(.CAUSE_W(CAUSE_W)) u_cls (
      .clk         (clk),
      .rst         (rst),
      .evt_valid   (evt_valid),
      .evt_code    (codes[c]),
      .clr_req     (reg_wr_en && reg_wr_data[STAT_LSB+c]),
      .rpt_mode    (mode_q[c]),
      .host_rst    (host_in_reset),
      .serr_cmd_en (serr_cmd_en),
      .status_q    (stat[c]),
      .cause_q     (causes[c]),
      .smi_on_q    (smi_on[c]),
      .smi_off_q   (smi_off[c]),
      .serr_q      (serr_v[c])
    );
  end

  flash_err_block u_blk (
    .clk          (clk),
    .rst          (rst),
    .slave_mode   (slave_mode),
    .blk_en       (blk_en_q),
    .nf_fetch_err (evt_valid && evt_cpl_fetch && (evt_nf_cause == NF_FETCH_CODE)),
    .clr_req      (reg_wr_en && reg_wr_data[BLKD_BIT]),
    .blocked_q    (blocked)
  );

  always_comb begin
    reg_rd_data = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      reg_rd_data[MODE_LSB+MODE_W*c +: MODE_W]    = mode_q[c];
      reg_rd_data[STAT_LSB+c]                     = stat[c];
      reg_rd_data[CAUSE_LSB+CAUSE_W*c +: CAUSE_W] = causes[c];
    end
    reg_rd_data[BLKEN_BIT] = blk_en_q;
    reg_rd_data[BLKD_BIT]  = blocked;
    reg_rd_data[EMPTY_BIT] = empty_q;
    reg_rd_data[PRIO_BIT]  = prio_q;
  end

  assign smi_assert   = |smi_on;
  assign smi_deassert = |smi_off;
  assign serr_req     = |serr_v;
  assign sse_set      = |serr_v;
  assign chan_block   = blocked;

  // R12
  empty_master_chk: assert property (@(posedge clk) disable iff (rst)
    !slave_mode |=> reg_rd_data[EMPTY_BIT]);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_wr_en |=> (reg_rd_data[DATA_W-1:PRIO_BIT+1] == '0));
endmodule

// File: tb/sim_flash_err_capture.sv
module sim_flash_err_capture;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rd;
  logic        ev_valid = 1'b0;
  logic [3:0]  nf_code = '0, fat_code = '0;
  logic        fetch = 1'b0, slave = 1'b0, cam_empty = 1'b1;
  logic        host_rst = 1'b0, serr_en = 1'b0;
  logic        smi_a, smi_d, serr, sse, blk;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_err_capture u0 (
    .clk(clk), .rst(rst), .reg_wr_en(wr_en), .reg_wr_data(wdata), .reg_rd_data(rd),
    .evt_valid(ev_valid), .evt_nf_cause(nf_code), .evt_fat_cause(fat_code),
    .evt_cpl_fetch(fetch), .slave_mode(slave), .np_table_empty(cam_empty),
    .host_in_reset(host_rst), .serr_cmd_en(serr_en),
    .smi_assert(smi_a), .smi_deassert(smi_d), .serr_req(serr), .sse_set(sse),
    .chan_block(blk));

  // behavioural reference model
  int m_st[2], m_cs[2], m_mode[2];
  bit m_blk_en, m_prio, m_blocked, m_empty, e_sa, e_sd, e_se;

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++) begin m_st[c] = 0; m_cs[c] = 0; m_mode[c] = 0; end
      m_blk_en = 0; m_prio = 1; m_blocked = 0; m_empty = 1;
      e_sa = 0; e_sd = 0; e_se = 0;
    end else begin
      bit set_b;
      e_sa = 0; e_sd = 0; e_se = 0;
      for (int c = 0; c < 2; c++) begin
        int code;
        bit hit, clr;
        code = (c == 0) ? int'(nf_code) : int'(fat_code);
        hit = ev_valid && code != 0;
        clr = wr_en && wdata[4+c];
        if (!host_rst) begin
          if (hit && m_st[c] == 0 && m_mode[c] == 3) e_sa = 1;
          if (hit && m_st[c] == 0 && m_mode[c] == 2 && serr_en) e_se = 1;
          if (clr && m_st[c] == 1 && !hit && m_mode[c] == 3) e_sd = 1;
        end
        if (hit && (m_st[c] == 0 || clr)) m_cs[c] = code;
        if (hit) m_st[c] = 1;
        else if (clr) m_st[c] = 0;
      end
      set_b = ev_valid && nf_code == 4'd1 && fetch && slave && m_blk_en;
      if (set_b) m_blocked = 1;
      else if (wr_en && wdata[17]) m_blocked = 0;
      if (wr_en) begin
        m_mode[0] = int'(wdata[1:0]); m_mode[1] = int'(wdata[3:2]);
        m_blk_en = wdata[16]; m_prio = wdata[19];
      end
      m_empty = slave ? cam_empty : 1'b1;
    end
  end

  function automatic logic [31:0] model_rd();
    logic [31:0] v;
    v = '0;
    v[1:0] = 2'(m_mode[0]); v[3:2] = 2'(m_mode[1]);
    v[4] = m_st[0][0]; v[5] = m_st[1][0];
    v[11:8] = 4'(m_cs[0]); v[15:12] = 4'(m_cs[1]);
    v[16] = m_blk_en; v[17] = m_blocked; v[18] = m_empty; v[19] = m_prio;
    return v;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      chk(rd, model_rd(), "R2-R5 model register");
      chk({31'b0, smi_a}, {31'b0, e_sa}, "R6 model smi_assert");
      chk({31'b0, smi_d}, {31'b0, e_sd}, "R7 model smi_deassert");
      chk({31'b0, serr}, {31'b0, e_se}, "R8 model serr_req");
      chk({31'b0, sse}, {31'b0, e_se}, "R8 model sse_set");
      chk({31'b0, blk}, {31'b0, m_blocked}, "R11 model chan_block");
    end
  end

  task automatic idle();
    @(negedge clk);
  endtask
  task automatic ev(input logic [3:0] nf, input logic [3:0] ft, input logic f);
    ev_valid = 1; nf_code = nf; fat_code = ft; fetch = f;
    @(negedge clk);
    ev_valid = 0; nf_code = 0; fat_code = 0; fetch = 0;
  endtask
  task automatic wr(input logic [31:0] d);
    wr_en = 1; wdata = d;
    @(negedge clk);
    wr_en = 0; wdata = '0;
  endtask
  task automatic wr_ev(input logic [31:0] d, input logic [3:0] nf);
    wr_en = 1; wdata = d; ev_valid = 1; nf_code = nf;
    @(negedge clk);
    wr_en = 0; wdata = '0; ev_valid = 0; nf_code = 0;
  endtask

  initial begin
    #(CLK_P*200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(rd, 32'h000C_0000, "R1 reset register");
    chk({27'b0, smi_a, smi_d, serr, sse, blk}, 32'h0, "R1 reset outputs");
    // R2 field write, reserved ignored
    wr(32'hFFF0_FFCB);
    chk(rd, 32'h0004_000B, "R2 readback");
    serr_en = 1;
    // R3 / R6 first error
    ev(4'd3, 4'd0, 0);
    chk(rd[4], 1, "R3 nf status"); chk(rd[11:8], 3, "R3 nf cause");
    chk(smi_a, 1, "R6 smi assert");
    ev(4'd4, 4'd0, 0);
    chk(rd[11:8], 3, "R4 cause locked"); chk(smi_a, 0, "R6 no second pulse");
    // R5 / R7 clear
    wr(32'h1B);
    chk(rd[4], 0, "R5 cleared"); chk(smi_d, 1, "R7 deassert");
    ev(4'd1, 4'd0, 0);
    wr_ev(32'h1B, 4'd6);
    chk(rd[4], 1, "R4 clear+error status"); chk(rd[11:8], 6, "R4 clear+error cause");
    chk(smi_d, 0, "R7 no deassert on collision");
    wr(32'h1B);
    // R8 serr routing
    ev(4'd0, 4'd8, 0);
    chk(serr, 1, "R8 serr"); chk(sse, 1, "R8 sse"); chk(rd[15:12], 8, "R3 fat cause");
    wr(32'h2B);
    chk(smi_d, 0, "R7 serr class no deassert"); chk(rd[5], 0, "R5 fat clear");
    serr_en = 0;
    ev(4'd0, 4'd9, 0);
    chk(serr, 0, "R8 gated by cmd enable"); chk(rd[15:12], 9, "R3 fat cause 9");
    wr(32'h2B);
    serr_en = 1;
    // R10 both classes
    ev(4'd2, 4'd8, 0);
    chk(rd[11:8], 2, "R10 nf"); chk(rd[15:12], 8, "R10 fat");
    chk({smi_a, serr}, 2'b11, "R10 merged pulses");
    wr(32'h3B);
    // R9 host reset
    host_rst = 1;
    ev(4'd5, 4'd0, 0);
    chk(smi_a, 0, "R9 no assert"); chk(rd[4], 1, "R9 status still set");
    wr(32'h1B);
    chk(smi_d, 0, "R9 no deassert");
    host_rst = 0;
    // R6 modes 00 and 01
    wr(32'h08);
    ev(4'd1, 4'd0, 0);
    chk({smi_a, serr}, 0, "R6 mode 00 silent");
    wr(32'h18);
    wr(32'h09);
    ev(4'd1, 4'd0, 0);
    chk({smi_a, serr}, 0, "R6 mode 01 silent");
    wr(32'h19);
    // R11 blocking
    slave = 1;
    wr(32'h0001_0003);
    ev(4'd1, 4'd0, 1);
    chk(blk, 1, "R11 block"); chk(rd[17], 1, "R11 blocked bit");
    ev(4'd4, 4'd0, 1);
    chk(blk, 1, "R11 stays blocked");
    wr(32'h0003_0013);
    chk(blk, 0, "R11 cleared");
    wr(32'h0000_0003);
    ev(4'd1, 4'd0, 1);
    chk(blk, 0, "R11 needs enable");
    wr(32'h13);
    slave = 0;
    wr(32'h0001_0003);
    ev(4'd1, 4'd0, 1);
    chk(blk, 0, "R11 master never blocks");
    wr(32'h0001_0013);
    // R12 pending-empty
    slave = 1; cam_empty = 0;
    idle();
    chk(rd[18], 0, "R12 slave not empty");
    cam_empty = 1;
    idle();
    chk(rd[18], 1, "R12 slave empty");
    slave = 0; cam_empty = 0;
    idle();
    chk(rd[18], 1, "R12 master reads 1");
    // R2 priority
    wr(32'h0008_0000);
    chk(rd[19], 1, "R2 priority set");
    idle();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule